// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital control side of an eight-channel successive-approximation converter. Software sees one control/status byte and four 16-bit result registers on an 8-bit bus. Setting the start bit launches conversions. In single mode the block converts one chosen channel. In scan mode it sweeps part of a channel group repeatedly. Each conversion is a level handshake with the analog converter. The block holds a request high with a channel number and a conversion time. The converter answers with a one-cycle done strobe and a 10-bit code.

The eight channels fall into a lower group (0..3) and an upper group (4..7). A channel and its partner four places away share one result register. A completed single conversion or scan pass raises an end flag. Software clears the flag by writing 0 to it. The interrupt output is the flag gated by an enable bit. Each 16-bit result is read as two bytes. Reading the high byte latches the low byte into a holding register, so a later low-byte read returns data from the same conversion. A standby request empties every result register.

Byte map: offsets 0..7 are result bytes. Register k has its high byte at 2k and its low byte at 2k+1. Offset 8 is the control/status byte. Every other offset reads 0.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, the control/status byte reads 0x00 and all eight result bytes read 0x00.
- R2: Control/status bit 7 is the end flag. Writing 0 to it clears it. Writing 1 leaves it unchanged. Hardware sets it when a single conversion or a scan pass completes.
- R3: Bit 5 is start. Bits 2..0 are the channel. In single mode (bit 4 = 0), exactly one conversion runs on that channel. The block then sets the end flag and clears start by itself.
- R4: In scan mode (bit 4 = 1), channels are converted in ascending order. Each pass runs from the first channel of the selected channel's group up to the selected channel. The end flag is set after every pass, and passes repeat while start stays 1.
- R5: Clearing start while a conversion is in flight drops the converter request within one cycle. No result is stored, and the end flag is not set.
- R6: Channels n and n+4 store into result register n mod 4.
- R7: A 10-bit result sits in bits 15..6 of its register. Bits 5..0 read 0.
- R8: A high-byte read copies that register's low byte into a holding register. A low-byte read returns the holding register, even if a newer conversion has since been stored.
- R9: `irq` equals the end flag ANDed with bit 6 (interrupt enable).
- R10: Bit 3 selects the conversion time sent on `cnv_time`: 266 clocks when 0, 134 clocks when 1. The value is latched when each conversion launches.
- R11: A `standby` pulse sets every result register and the holding register to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| standby | input | 1 | Clears the result registers and the holding register |
| bus_addr | input | 4 | Byte offset |
| bus_wr | input | 1 | Write strobe (control/status byte only) |
| bus_rd | input | 1 | Read strobe; a high-byte read updates the holding register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| irq | output | 1 | Conversion-end interrupt |
| cnv_req | output | 1 | Converter request, held for the whole conversion |
| cnv_chan | output | 3 | Channel being converted |
| cnv_time | output | 9 | Conversion length in clocks |
| cnv_done | input | 1 | One-cycle completion strobe from the converter |
| cnv_result | input | 10 | Converted code, valid with cnv_done |

## Verification
The hardest situation to reach is a stale holding register. The bench reads the high byte of a shared register and then runs a fresh conversion on the partner channel of the other group. Only after that does it read the low byte, which must still show the older value. Repeated scan passes are also hard to observe. The bench clears the flag between passes while keeping start set, and afterwards it compares the full log of converted channels. Aborts are reached by clearing start partway through a 266-clock conversion. Random single conversions draw their channel, timing bit and interrupt enable from a fixed-seed generator.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the ADC conversion sequencer.
// Assumes an 8-bit control/status byte whose bit order software relies on.
package adc_seq_pkg;

    // Control/status byte; field order is the bus bit order (bit 7 first).
    typedef struct packed {
        logic       flag;   // bit 7: end of conversion / pass
        logic       ie;     // bit 6: interrupt enable
        logic       start;  // bit 5: run
        logic       scan;   // bit 4: scan mode
        logic       cks;    // bit 3: short conversion time
        logic [2:0] ch;     // bits 2..0: channel
    } ctrl_reg_t;

    // Sequencer states.
    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_BUSY = 1'b1
    } seq_state_e;

endpackage

// File: rtl/adc_ctrl_reg.sv
`timescale 1ns/1ps
// Module: adc_ctrl_reg
// Holds the control/status byte. Software writes bits 6..0 directly.
// Bit 7 can only be cleared by writing 0; hardware sets it on pass_done.
// single_end clears start unless a bus write lands in the same cycle.
// Assumes pass_done and single_end are single-cycle pulses.
module adc_ctrl_reg
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    input  logic       pass_done,
    input  logic       single_end,
    output ctrl_reg_t  ctrl
);

    // Update the control fields from the bus or from sequencer events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else begin
            if (wr_en) begin
                ctrl.ie    <= wdata[6];
                ctrl.start <= wdata[5];
                ctrl.scan  <= wdata[4];
                ctrl.cks   <= wdata[3];
                ctrl.ch    <= wdata[2:0];
            end else if (single_end) begin
                ctrl.start <= 1'b0;
            end
            if (pass_done) begin
                ctrl.flag <= 1'b1;
            end else if (wr_en && !wdata[7]) begin
                ctrl.flag <= 1'b0;
            end
        end
    end

    // R2: the flag only rises after a completed conversion or pass.
    assert_flag_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl.flag) |-> $past(pass_done));

    // R2: writing 1 to bit 7 never raises the flag.
    assert_flag_write_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[7] && !ctrl.flag && !pass_done) |=> !ctrl.flag);

    // R3: a finished single conversion stops the run.
    assert_single_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (single_end && !wr_en) |=> !ctrl.start);

endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
// Module: adc_seq_ctrl
// Drives the converter handshake. The request stays high for the whole
// conversion, and the channel and time are held steady. After each done
// strobe the request drops for one cycle before the next launch.
// Assumes the converter resets itself whenever the request is low.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CH_W   = 3,
    parameter int DATA_W = 10,
    parameter int TIME_W = 9,
    parameter int T_SLOW = 266,
    parameter int T_FAST = 134
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              scan,
    input  logic              cks,
    input  logic [CH_W-1:0]   ch_sel,
    input  logic              cnv_done,
    input  logic [DATA_W-1:0] cnv_result,
    output logic              cnv_req,
    output logic [CH_W-1:0]   cnv_chan,
    output logic [TIME_W-1:0] cnv_time,
    output logic              store_en,
    output logic [CH_W-2:0]   store_idx,
    output logic [DATA_W-1:0] store_data,
    output logic              pass_done,
    output logic              single_end
);

    localparam int GRP_W = CH_W - 1;

    seq_state_e        state_q;
    logic              mode_q;    // 1 = scan for the running sequence
    logic              in_pass_q; // a scan sequence is in progress
    logic [CH_W-1:0]   chan_q;
    logic [CH_W-1:0]   last_q;
    logic [TIME_W-1:0] time_q;
    logic              is_last;

    assign is_last = (chan_q == last_q);

    // Launch, abort and advance the conversion sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SEQ_IDLE;
            mode_q    <= 1'b0;
            in_pass_q <= 1'b0;
            chan_q    <= '0;
            last_q    <= '0;
            time_q    <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        state_q <= SEQ_BUSY;
                        time_q  <= cks ? TIME_W'(T_FAST) : TIME_W'(T_SLOW);
                        if (!in_pass_q) begin
                            mode_q <= scan;
                            last_q <= ch_sel;
                            chan_q <= scan ? {ch_sel[CH_W-1], {GRP_W{1'b0}}} : ch_sel;
                        end
                    end else begin
                        in_pass_q <= 1'b0;
                    end
                end
                default: begin
                    if (!start) begin
                        state_q   <= SEQ_IDLE;
                        in_pass_q <= 1'b0;
                    end else if (cnv_done) begin
                        state_q <= SEQ_IDLE;
                        if (!mode_q) begin
                            in_pass_q <= 1'b0;
                        end else begin
                            in_pass_q <= 1'b1;
                            chan_q    <= is_last ? {chan_q[CH_W-1], {GRP_W{1'b0}}}
                                                 : chan_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // Converter handshake and result routing.
    always_comb begin
        cnv_req    = (state_q == SEQ_BUSY);
        cnv_chan   = chan_q;
        cnv_time   = time_q;
        store_en   = cnv_req && start && cnv_done;
        store_idx  = chan_q[GRP_W-1:0];
        store_data = cnv_result;
        pass_done  = store_en && (!mode_q || is_last);
        single_end = store_en && !mode_q;
    end

    // R5: once start is low, the request is gone on the next cycle.
    assert_req_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !cnv_req);

    // R4: the channel and time are steady while a request is held.
    assert_chan_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnv_req && $past(cnv_req)) |-> ($stable(cnv_chan) && $stable(cnv_time)));

    // R10: only the two legal conversion times are ever requested.
    assert_time_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_req |-> (cnv_time == TIME_W'(T_SLOW) || cnv_time == TIME_W'(T_FAST)));

endmodule

// File: rtl/adc_result_bank.sv
`timescale 1ns/1ps
// Module: adc_result_bank
// Result registers holding left-justified codes, plus the low-byte
// holding register and the byte read mux. A high-byte read copies
// the low byte into the holding register at the clock edge.
// Assumes byte offset 2k is the high byte and 2k+1 the low byte of register k.
module adc_result_bank #(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 10,
    parameter int REG_W    = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        standby,
    input  logic                        store_en,
    input  logic [$clog2(NUM_REGS)-1:0] store_idx,
    input  logic [DATA_W-1:0]           store_data,
    input  logic                        rd_en,
    input  logic [$clog2(NUM_REGS):0]   rd_addr,
    output logic [7:0]                  rd_data
);

    localparam int IDX_W = $clog2(NUM_REGS);
    localparam int PAD_W = REG_W - DATA_W;

    logic [DATA_W-1:0] res_q [NUM_REGS];
    logic [REG_W-1:0]  sel_word;
    logic [7:0]        temp_q;
    logic              hi_read;

    // One register per pair of channels.
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        // Load on a matching store; standby or reset empties it.
        always_ff @(posedge clk) begin
            if (!rst_n || standby) begin
                res_q[i] <= '0;
            end else if (store_en && store_idx == IDX_W'(i)) begin
                res_q[i] <= store_data;
            end
        end

        // R11: standby leaves the register empty.
        assert_standby_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
            standby |=> (res_q[i] == '0));
    end

    assign hi_read  = rd_en && !rd_addr[0];
    assign sel_word = {res_q[rd_addr[IDX_W:1]], {PAD_W{1'b0}}};

    // Capture the low byte when the high byte is read.
    always_ff @(posedge clk) begin
        if (!rst_n || standby) begin
            temp_q <= '0;
        end else if (hi_read) begin
            temp_q <= sel_word[7:0];
        end
    end

    // Byte read mux: high byte live, low byte from the holding register.
    assign rd_data = rd_addr[0] ? temp_q : sel_word[REG_W-1:REG_W-8];

    // R8: the holding register only changes on a high-byte read or standby.
    assert_temp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_read && !standby) |=> $stable(temp_q));

    // R7: pad bits of the holding register stay zero.
    assert_pad_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        temp_q[PAD_W-1:0] == '0);

endmodule

// File: rtl/adc_seq_top.sv
`timescale 1ns/1ps
// Module: adc_seq_top
// Top of the ADC conversion sequencer. Decodes the byte bus onto the
// control register and the result bank, and wires the sequencer to the
// converter handshake. Offsets 0..7 hold results, and offset 8 is control.
// Assumes one bus access per cycle and that reads have no side effect
// beyond the low-byte latch.
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int DATA_W   = 10,
    parameter int TIME_W   = 9,
    parameter int T_SLOW   = 266,
    parameter int T_FAST   = 134
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby,
    input  logic [3:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq,
    output logic              cnv_req,
    output logic [2:0]        cnv_chan,
    output logic [TIME_W-1:0] cnv_time,
    input  logic              cnv_done,
    input  logic [DATA_W-1:0] cnv_result
);

    localparam int CH_W     = $clog2(NUM_CH);
    localparam int NUM_REGS = NUM_CH / 2;
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam logic [3:0] CTRL_OFS = 4'h8;

    ctrl_reg_t         ctrl;
    logic              ctrl_wr;
    logic              bank_rd;
    logic [7:0]        bank_data;
    logic              store_en;
    logic [IDX_W-1:0]  store_idx;
    logic [DATA_W-1:0] store_data;
    logic              pass_done;
    logic              single_end;

    assign ctrl_wr = bus_wr && (bus_addr == CTRL_OFS);
    assign bank_rd = bus_rd && !bus_addr[3];

    adc_ctrl_reg i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (ctrl_wr),
        .wdata      (bus_wdata),
        .pass_done  (pass_done),
        .single_end (single_end),
        .ctrl       (ctrl)
    );

    adc_seq_ctrl #(
        .CH_W   (CH_W),
        .DATA_W (DATA_W),
        .TIME_W (TIME_W),
        .T_SLOW (T_SLOW),
        .T_FAST (T_FAST)
    ) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (ctrl.start),
        .scan       (ctrl.scan),
        .cks        (ctrl.cks),
        .ch_sel     (ctrl.ch),
        .cnv_done   (cnv_done),
        .cnv_result (cnv_result),
        .cnv_req    (cnv_req),
        .cnv_chan   (cnv_chan),
        .cnv_time   (cnv_time),
        .store_en   (store_en),
        .store_idx  (store_idx),
        .store_data (store_data),
        .pass_done  (pass_done),
        .single_end (single_end)
    );

    adc_result_bank #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .REG_W    (16)
    ) i_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .standby    (standby),
        .store_en   (store_en),
        .store_idx  (store_idx),
        .store_data (store_data),
        .rd_en      (bank_rd),
        .rd_addr    (bus_addr[IDX_W:0]),
        .rd_data    (bank_data)
    );

    // Byte read mux across the bank and the control byte.
    always_comb begin
        if (!bus_addr[3])            bus_rdata = bank_data;
        else if (bus_addr == CTRL_OFS) bus_rdata = ctrl;
        else                         bus_rdata = 8'h00;
    end

    assign irq = ctrl.flag && ctrl.ie;

    // R9: an interrupt is only raised while enabled.
    assert_irq_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (bus_addr != CTRL_OFS || !bus_rd || bus_rdata[6]));

endmodule

// File: tb/test_adc_seq_top.sv
`timescale 1ns/1ps
module test_adc_seq_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       standby = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq;
    logic       cnv_req;
    logic [2:0] cnv_chan;
    logic [8:0] cnv_time;
    logic       cnv_done = 1'b0;
    logic [9:0] cnv_result = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    adc_seq_top i_adc_seq_top (
        .clk(clk), .rst_n(rst_n), .standby(standby),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .cnv_req(cnv_req), .cnv_chan(cnv_chan), .cnv_time(cnv_time),
        .cnv_done(cnv_done), .cnv_result(cnv_result)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Expected conversion time from the timing bit (R10).
    function automatic int exp_time_of(bit cks);
        return cks ? 134 : 266;
    endfunction

    // Expected high / low bytes of a left-justified 10-bit code (R7).
    function automatic int hi_of(logic [9:0] v);
        return int'(v[9:2]);
    endfunction
    function automatic int lo_of(logic [9:0] v);
        return int'({v[1:0], 6'b0});
    endfunction

    // Behavioural converter plus a log of completed conversions.
    logic [9:0] exp_val [4];
    int         log_ch [512];
    int         log_n = 0;
    int         exp_time = 266;
    bit         m_busy = 0;
    int         m_cnt = 0;
    int         m_time = 0;
    logic [2:0] m_chan = '0;

    initial for (int i = 0; i < 4; i++) exp_val[i] = '0;

    always @(posedge clk) begin
        if (!cnv_req) begin
            m_busy   <= 0;
            cnv_done <= 0;
        end else if (!m_busy && !cnv_done) begin
            m_busy <= 1;
            m_cnt  <= 1;
            m_chan <= cnv_chan;
            m_time <= int'(cnv_time);
            check("R10 cnv_time", int'(cnv_time), exp_time);
        end else if (m_busy) begin
            if (m_cnt >= m_time - 1) begin
                logic [9:0] v;
                v = 10'($urandom);
                cnv_done   <= 1;
                cnv_result <= v;
                m_busy     <= 0;
                exp_val[m_chan[1:0]] = v;
                log_ch[log_n % 512] = int'(m_chan);
                log_n = log_n + 1;
            end else begin
                m_cnt <= m_cnt + 1;
            end
        end else begin
            cnv_done <= 0;
        end
    end

    task automatic bus_write(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic wait_flag(output bit seen);
        logic [7:0] c;
        seen = 0;
        for (int i = 0; i < 4000; i++) begin
            bus_read(4'h8, c);
            if (c[7]) begin seen = 1; break; end
        end
    endtask

    task automatic start_cfg(bit ie, bit scan, bit cks, logic [2:0] ch);
        exp_time = exp_time_of(cks);
        bus_write(4'h8, {1'b0, ie, 1'b1, scan, cks, ch});
    endtask

    initial begin
        #(5.0 * 190000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, old_lo;
        bit seen;
        int n0;
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values.
        bus_read(4'h8, d); check("R1 ctrl after reset", d, 0);
        for (int a = 0; a < 8; a++) begin
            bus_read(4'(a), d); check("R1 result byte after reset", d, 0);
        end
        check("R1 irq after reset", irq, 0);

        // R3 R6 R7 R9 R10: random single conversions.
        for (int k = 0; k < 8; k++) begin
            logic [2:0] ch; bit cks, ie;
            ch = 3'($urandom); cks = 1'($urandom); ie = 1'($urandom);
            if (k == 0) begin ch = 3'd7; cks = 1'b0; ie = 1'b1; end
            if (k == 1) begin ch = 3'd0; cks = 1'b1; ie = 1'b0; end
            n0 = log_n;
            start_cfg(ie, 1'b0, cks, ch);
            wait_flag(seen);
            check("R3 single end flag", seen, 1);
            bus_read(4'h8, d);
            check("R3 start self-clears", d[5], 0);
            check("R9 irq is flag and enable", irq, ie);
            check("R3 exactly one conversion", log_n - n0, 1);
            check("R3 converted channel", log_ch[n0 % 512], int'(ch));
            bus_read({1'b0, ch[1:0], 1'b0}, d);
            check("R6 high byte in paired register", d, hi_of(exp_val[ch[1:0]]));
            bus_read({1'b0, ch[1:0], 1'b1}, d);
            check("R7 low byte left-justified", d, lo_of(exp_val[ch[1:0]]));
        end

        // R2: writing 1 to the flag keeps it, writing 0 clears it.
        bus_write(4'h8, 8'h80);
        bus_read(4'h8, d); check("R2 write 1 keeps flag", d, 8'h80);
        bus_write(4'h8, 8'h40);
        bus_read(4'h8, d); check("R2 write 0 clears flag", d, 8'h40);
        check("R9 irq low with flag clear", irq, 0);
        bus_write(4'h8, 8'hC0);
        bus_read(4'h8, d); check("R2 write 1 cannot set flag", d, 8'h40);

        // R8: low byte comes from the holding register.
        start_cfg(1'b0, 1'b0, 1'b1, 3'd1);
        wait_flag(seen);
        bus_read(4'h2, d);
        old_lo = 8'(lo_of(exp_val[1]));
        start_cfg(1'b0, 1'b0, 1'b1, 3'd5);
        wait_flag(seen);
        bus_read(4'h3, d); check("R8 low byte is latched copy", d, old_lo);
        bus_read(4'h2, d); check("R6 channel 5 into register B", d, hi_of(exp_val[1]));
        bus_read(4'h3, d); check("R8 low byte after new high read", d, lo_of(exp_val[1]));

        // R4: scan group 1 up to channel 6, two passes.
        n0 = log_n;
        start_cfg(1'b0, 1'b1, 1'b0, 3'd6);
        wait_flag(seen); check("R4 first pass flag", seen, 1);
        bus_write(4'h8, 8'h36);
        bus_read(4'h8, d); check("R4 start held in scan", d[5], 1);
        wait_flag(seen); check("R4 second pass flag", seen, 1);
        bus_write(4'h8, 8'h16);
        repeat (3) @(posedge clk);
        check("R5 request dropped after stop", cnv_req, 0);
        check("R4 at least two passes", (log_n - n0) >= 6, 1);
        for (int k = 0; k < log_n - n0; k++)
            check("R4 ascending channel order", log_ch[(n0 + k) % 512], 4 + (k % 3));
        n0 = log_n;
        repeat (700) @(posedge clk);
        check("R5 no conversion after stop", log_n - n0, 0);
        for (int r = 0; r < 3; r++) begin
            bus_read(4'(2 * r), d);
            check("R6 scan result in paired register", d, hi_of(exp_val[r]));
        end

        // R4: scan of the lower group at channel 0 runs a single-channel pass.
        n0 = log_n;
        start_cfg(1'b0, 1'b1, 1'b1, 3'd0);
        wait_flag(seen); check("R4 one-channel pass flag", seen, 1);
        bus_write(4'h8, 8'h08);
        repeat (3) @(posedge clk);
        for (int k = 0; k < log_n - n0; k++)
            check("R4 channel 0 only", log_ch[(n0 + k) % 512], 0);

        // R5: abort a single conversion partway.
        bus_read(4'h4, d);
        old_lo = d;
        n0 = log_n;
        start_cfg(1'b0, 1'b0, 1'b0, 3'd2);
        repeat (60) @(posedge clk);
        bus_write(4'h8, 8'h02);
        repeat (2) @(posedge clk);
        check("R5 request low after abort", cnv_req, 0);
        repeat (400) @(posedge clk);
        bus_read(4'h8, d); check("R5 no flag after abort", d, 8'h02);
        check("R5 no conversion completed", log_n - n0, 0);
        bus_read(4'h4, d); check("R5 result unchanged", d, old_lo);

        // R11: standby empties the results.
        @(negedge clk) standby = 1'b1;
        @(negedge clk) standby = 1'b0;
        for (int a = 0; a < 8; a++) begin
            bus_read(4'(a), d); check("R11 result byte after standby", d, 0);
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule